// File: doc/BRIEF.md
# Per-Channel Eye Scan Calibrator

The calibrator picks the sampling delay of every data channel of a synchronous capture front end on its own. On a start pulse it steps a data-delay tap select through a span of 101 taps of about 100 ps each (10 ns in all, centred on the capture clock edge, with tap 50 at the edge). At each tap it compares, for every channel, the sample taken at that tap with the sample taken at the next tap. If they ever differ during a fixed number of observed clock edges, the tap is marked as a transition tap.

When the sweep ends, each channel searches its 101-bit transition map for the longest run of stable taps. It places its sample tap at the middle of that run. It raises a fail flag when the run is narrower than the setup-plus-hold window. A per-channel override can replace the computed tap, and software can read each map once the block is idle.

The external delay line, which turns the tap select into two delayed samples per channel, lies outside this block. In double-edge mode that line also supplies a pair of samples captured on the falling edge.

Top module: `eyescan_cal`

## Requirements
- R1: After reset, busy and done are 0, every channel reports tap 50 with fail 0, and map_out reads all zeros.
- R2: When idle, a start pulse begins a sweep. tap_sel then takes the values 0, 1, … 99 in that order. Each value is held for one settle cycle plus OBS_EDGES/E observing cycles, where E is 1 in single-edge mode and 2 in double-edge mode.
- R3: Bit k of a channel's map (k in 0..99) is set exactly when samp_cur_r and samp_nxt_r of that channel differ in at least one observing cycle of tap k. Samples taken in the settle cycle are ignored. Bit 100 is always 0.
- R4: dual_edge is sampled with start. When it is 1, a mismatch between samp_cur_f and samp_nxt_f also marks the tap. When it is 0, those inputs have no effect.
- R5: The selected tap is s + floor((L-1)/2), where s and L are the start and length of the longest run of 0 bits in the channel's map. When two runs have equal length, the one with the lower start wins.
- R6: A channel's fail flag is 1 exactly when its longest stable run is shorter than MIN_RUN (13) taps.
- R7: A channel whose map has no transition bits selects tap 50 and does not fail.
- R8: Each channel's map, tap and fail depend only on that channel's own sample inputs.
- R9: When ovr_en[c] is 1 and ovr_tap for channel c is at most 100, sel_tap for c equals ovr_tap. If the override is disabled or out of range, sel_tap shows the computed tap. The fail flag is never affected by the override.
- R10: While busy, map_out is all zeros. While idle, it shows the map of channel map_ch, with bit k for tap k.
- R11: An accepted start sets every map to zero, every fail flag to 0 and every tap to 50 by the first busy cycle. A start pulse while busy is ignored.
- R12: busy rises in the cycle after start and stays high for exactly 100·(1+OBS_EDGES/E)+103 cycles. done is a one-cycle pulse in the first cycle with busy low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture-domain clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a calibration sweep (pulse) |
| dual_edge | input | 1 | 1: observe falling-edge sample pair as well |
| busy | output | 1 | Sweep or search in progress |
| done | output | 1 | One-cycle completion pulse |
| tap_sel | output | 7 | Tap index to the external delay line |
| samp_cur_r | input | NCH | Rising-edge sample at current tap, per channel |
| samp_nxt_r | input | NCH | Rising-edge sample at next tap, per channel |
| samp_cur_f | input | NCH | Falling-edge sample at current tap, per channel |
| samp_nxt_f | input | NCH | Falling-edge sample at next tap, per channel |
| ovr_en | input | NCH | Per-channel override enable |
| ovr_tap | input | NCH*7 | Per-channel override tap, channel c in bits [7c+6:7c] |
| sel_tap | output | NCH*7 | Per-channel chosen tap, channel c in bits [7c+6:7c] |
| fail | output | NCH | Per-channel narrow-eye flag |
| map_ch | input | CH_W | Channel whose map is shown |
| map_out | output | 101 | Transition map of map_ch, zero while busy |

## Verification
The assertions assume several things about the inputs. The delay line settles within the single cycle after tap_sel moves. OBS_EDGES is even whenever double-edge mode is used. start only matters in idle cycles. Under these assumptions the tap select only ever advances by one, stays below 100, and the picked tap always lies in a stable part of the map. The bench keeps to these assumptions by recomputing every sample pair at the falling clock edge that follows a tap change. It places sparse mismatches only at known settle or observing phases, and it issues extra start pulses only to probe that they are ignored.

// File: rtl/eyescan_pkg.sv
// Shared types of the eye scan calibrator.
package eyescan_pkg;
    // Sequencer phases: idle, delay-line settle, observation, map search, result load.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_SCAN,
        ST_SEARCH,
        ST_FINISH
    } sweep_st_e;
endpackage

// File: rtl/eyescan_sweep.sv
// Sweep sequencer. Steps the tap select across taps 0..NTAPS-2, holding each for
// one settle cycle plus OBS_EDGES observed edges, then steps a search index over
// 0..NTAPS (the last value closes any open run) and pulses done.
// Assumes OBS_EDGES is even when double-edge mode is used and NTAPS < 2**TAP_W.
module eyescan_sweep
    import eyescan_pkg::*;
#(
    parameter int NTAPS     = 101,
    parameter int OBS_EDGES = 256,
    parameter int TAP_W     = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             dual_edge,
    output logic             busy,
    output logic             done,
    output logic [TAP_W-1:0] tap_sel,
    output logic             clear,
    output logic             obs_en,
    output logic             obs_dual,
    output logic             tap_wr,
    output logic             srch_en,
    output logic [TAP_W-1:0] srch_idx,
    output logic             finish
);
    localparam int CNT_W = $clog2(OBS_EDGES + 2);

    sweep_st_e          st;
    logic [TAP_W-1:0]   tap;
    logic [CNT_W-1:0]   cnt;
    logic [CNT_W:0]     cnt_nxt;
    logic [CNT_W:0]     step;
    logic               dual_q;
    logic               last_obs;
    logic [TAP_W-1:0]   idx;

    // Edge budget: one or two observed edges per cycle.
    always_comb begin
        step     = dual_q ? (CNT_W+1)'(2) : (CNT_W+1)'(1);
        cnt_nxt  = {1'b0, cnt} + step;
        last_obs = (cnt_nxt >= (CNT_W+1)'(OBS_EDGES));
    end

    // Phase sequencing, tap stepping and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            tap    <= '0;
            cnt    <= '0;
            dual_q <= 1'b0;
            idx    <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: if (start) begin
                    st     <= ST_SETTLE;
                    tap    <= '0;
                    dual_q <= dual_edge;
                end
                ST_SETTLE: begin
                    st  <= ST_SCAN;
                    cnt <= '0;
                end
                ST_SCAN: begin
                    if (last_obs) begin
                        cnt <= '0;
                        if (tap == TAP_W'(NTAPS - 2)) begin
                            st  <= ST_SEARCH;
                            idx <= '0;
                        end else begin
                            tap <= tap + 1'b1;
                            st  <= ST_SETTLE;
                        end
                    end else begin
                        cnt <= cnt_nxt[CNT_W-1:0];
                    end
                end
                ST_SEARCH: begin
                    idx <= idx + 1'b1;
                    if (idx == TAP_W'(NTAPS)) st <= ST_FINISH;
                end
                ST_FINISH: begin
                    done <= 1'b1;
                    st   <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Strobes towards the channel units.
    always_comb begin
        busy     = (st != ST_IDLE);
        clear    = (st == ST_IDLE) && start;
        obs_en   = (st == ST_SCAN);
        obs_dual = dual_q;
        tap_wr   = (st == ST_SCAN) && last_obs;
        srch_en  = (st == ST_SEARCH);
        srch_idx = idx;
        finish   = (st == ST_FINISH);
        tap_sel  = tap;
    end

    // R12: done lasts exactly one cycle
    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R12: done arrives as busy drops
    a_r12_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));
    // R2: tap select only advances by one during a sweep
    a_r2_tap_step: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && tap_sel != $past(tap_sel)) |-> (tap_sel == $past(tap_sel) + 1'b1));
    // R2: tap select never reaches the last tap
    a_r2_tap_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (tap_sel <= TAP_W'(NTAPS - 2)));
endmodule

// File: rtl/eyescan_chan.sv
// One channel: accumulates sample mismatches per tap into a transition map,
// scans the map for the longest stable run (first one wins on a tie) and loads
// the centre tap (rounded down) and the narrow-eye flag on finish.
// Assumes the sequencer drives srch_idx 0..NTAPS, one value per srch_en cycle.
module eyescan_chan #(
    parameter int NTAPS   = 101,
    parameter int TAP_W   = 7,
    parameter int MIN_RUN = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             obs_en,
    input  logic             obs_dual,
    input  logic             tap_wr,
    input  logic [TAP_W-1:0] tap_idx,
    input  logic             cur_r,
    input  logic             nxt_r,
    input  logic             cur_f,
    input  logic             nxt_f,
    input  logic             srch_en,
    input  logic [TAP_W-1:0] srch_idx,
    input  logic             finish,
    output logic [NTAPS-1:0] map,
    output logic [TAP_W-1:0] res_tap,
    output logic             res_fail
);
    localparam logic [TAP_W-1:0] CENTER = TAP_W'(NTAPS / 2);

    logic             seen;
    logic             acc;
    logic             stable_here;
    logic [TAP_W-1:0] run_len, run_st, best_len, best_st;

    // Mismatch between neighbouring taps on any observed edge of this cycle.
    always_comb begin
        seen        = (cur_r ^ nxt_r) | (obs_dual & (cur_f ^ nxt_f));
        stable_here = (srch_idx < TAP_W'(NTAPS)) && !map[srch_idx];
    end

    // Sticky mismatch flag for the tap being observed.
    always_ff @(posedge clk) begin
        if (!rst_n)               acc <= 1'b0;
        else if (clear || tap_wr) acc <= 1'b0;
        else if (obs_en && seen)  acc <= 1'b1;
    end

    // Transition map write at the end of each tap.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) map <= '0;
        else if (tap_wr)     map[tap_idx] <= acc | seen;
    end

    // Longest stable run search, strict compare keeps the earliest run.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            run_len  <= '0;
            run_st   <= '0;
            best_len <= '0;
            best_st  <= '0;
        end else if (srch_en) begin
            if (stable_here) begin
                if (run_len == '0) run_st <= srch_idx;
                run_len <= run_len + 1'b1;
            end else begin
                if (run_len > best_len) begin
                    best_len <= run_len;
                    best_st  <= run_st;
                end
                run_len <= '0;
            end
        end
    end

    // Result load: centre of the best run and the narrow-eye flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            res_tap  <= CENTER;
            res_fail <= 1'b0;
        end else if (finish) begin
            res_tap  <= best_st + ((best_len - 1'b1) >> 1);
            res_fail <= (best_len < TAP_W'(MIN_RUN));
        end
    end

    // R11: an accepted start empties the map and the flag
    a_r11_clear_map: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (map == '0 && !res_fail));
    // R5: the picked tap lies inside the span and on a stable tap
    a_r5_pick_stable: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> (res_tap < TAP_W'(NTAPS) && !map[res_tap]));
endmodule

// File: rtl/eyescan_cal.sv
// Top of the eye scan calibrator: one sequencer shared by NCH channel units,
// per-channel override muxing, and the idle-only map readout.
// Assumes the external delay line presents both samples for tap_sel within the
// settle cycle following a tap change.
module eyescan_cal #(
    parameter int NCH       = 4,
    parameter int NTAPS     = 101,
    parameter int OBS_EDGES = 256,
    parameter int MIN_RUN   = 13,
    localparam int TAP_W    = $clog2(NTAPS),
    localparam int CH_W     = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 dual_edge,
    output logic                 busy,
    output logic                 done,
    output logic [TAP_W-1:0]     tap_sel,
    input  logic [NCH-1:0]       samp_cur_r,
    input  logic [NCH-1:0]       samp_nxt_r,
    input  logic [NCH-1:0]       samp_cur_f,
    input  logic [NCH-1:0]       samp_nxt_f,
    input  logic [NCH-1:0]       ovr_en,
    input  logic [NCH*TAP_W-1:0] ovr_tap,
    output logic [NCH*TAP_W-1:0] sel_tap,
    output logic [NCH-1:0]       fail,
    input  logic [CH_W-1:0]      map_ch,
    output logic [NTAPS-1:0]     map_out
);
    logic             clear, obs_en, obs_dual, tap_wr, srch_en, finish;
    logic [TAP_W-1:0] srch_idx;
    logic [NTAPS-1:0] maps [NCH];

    eyescan_sweep #(
        .NTAPS(NTAPS), .OBS_EDGES(OBS_EDGES), .TAP_W(TAP_W)
    ) u_sweep (
        .clk(clk), .rst_n(rst_n), .start(start), .dual_edge(dual_edge),
        .busy(busy), .done(done), .tap_sel(tap_sel), .clear(clear),
        .obs_en(obs_en), .obs_dual(obs_dual), .tap_wr(tap_wr),
        .srch_en(srch_en), .srch_idx(srch_idx), .finish(finish)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [TAP_W-1:0] res_tap;
        logic [TAP_W-1:0] ovr_c;
        logic             ovr_ok;

        eyescan_chan #(
            .NTAPS(NTAPS), .TAP_W(TAP_W), .MIN_RUN(MIN_RUN)
        ) u_chan (
            .clk(clk), .rst_n(rst_n), .clear(clear), .obs_en(obs_en),
            .obs_dual(obs_dual), .tap_wr(tap_wr), .tap_idx(tap_sel),
            .cur_r(samp_cur_r[c]), .nxt_r(samp_nxt_r[c]),
            .cur_f(samp_cur_f[c]), .nxt_f(samp_nxt_f[c]),
            .srch_en(srch_en), .srch_idx(srch_idx), .finish(finish),
            .map(maps[c]), .res_tap(res_tap), .res_fail(fail[c])
        );

        // Override wins only when enabled and inside the tap span.
        always_comb begin
            ovr_c  = ovr_tap[c*TAP_W +: TAP_W];
            ovr_ok = ovr_en[c] && (ovr_c < TAP_W'(NTAPS));
            sel_tap[c*TAP_W +: TAP_W] = ovr_ok ? ovr_c : res_tap;
        end
    end

    // Map readout, blanked while a sweep owns the maps.
    always_comb begin
        map_out = '0;
        if (!busy && (int'(map_ch) < NCH)) map_out = maps[map_ch];
    end
endmodule

// File: tb/eyescan_cal_bench.sv
// Bench: drives per-channel transition zones through the sample inputs and
// compares taps, flags, maps and timing with values computed here.
module eyescan_cal_bench;
    localparam int NCH = 4;
    localparam int OBS = 8;
    localparam int NT  = 101;
    localparam int TW  = 7;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, dual_edge = 1'b0;
    logic busy, done;
    logic [TW-1:0] tap_sel;
    logic [NCH-1:0] samp_cur_r = '0, samp_nxt_r = '0, samp_cur_f = '0, samp_nxt_f = '0;
    logic [NCH-1:0] ovr_en = '0;
    logic [NCH*TW-1:0] ovr_tap = '0;
    logic [NCH*TW-1:0] sel_tap;
    logic [NCH-1:0] fail;
    logic [1:0] map_ch = '0;
    logic [NT-1:0] map_out;

    eyescan_cal #(.NCH(NCH), .NTAPS(NT), .OBS_EDGES(OBS), .MIN_RUN(13)) u_eyescan_cal (
        .clk(clk), .rst_n(rst_n), .start(start), .dual_edge(dual_edge),
        .busy(busy), .done(done), .tap_sel(tap_sel),
        .samp_cur_r(samp_cur_r), .samp_nxt_r(samp_nxt_r),
        .samp_cur_f(samp_cur_f), .samp_nxt_f(samp_nxt_f),
        .ovr_en(ovr_en), .ovr_tap(ovr_tap), .sel_tap(sel_tap), .fail(fail),
        .map_ch(map_ch), .map_out(map_out)
    );

    always #4 clk = ~clk;

    int checks = 0, errors = 0, cycles = 0;
    logic [99:0] zr [NCH];
    logic [99:0] zf [NCH];
    int gph = -1;          // -1: mismatch every cycle in a zone, else only at this phase
    int phase = 0, hold = 0, bcnt = 0, sweep_err = 0, obs_len = OBS;
    logic [TW-1:0] prev_tap = '0;
    logic prev_busy = 1'b0, par = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // Sample model and sweep monitor, updated away from the active edge.
    always @(negedge clk) begin
        cycles++;
        if (tap_sel != prev_tap || (busy && !prev_busy)) begin
            if (busy && prev_busy && (tap_sel != prev_tap + 1'b1 || hold != 1 + obs_len)) sweep_err++;
            phase = 0;
            hold  = 1;
        end else begin
            phase++;
            hold++;
        end
        if (busy) bcnt++;
        prev_tap  = tap_sel;
        prev_busy = busy;
        par = ~par;
        for (int c = 0; c < NCH; c++) begin
            bit hit, gr, gf;
            hit = (gph < 0) || (phase == gph);
            gr  = (tap_sel < 100) && zr[c][tap_sel] && hit;
            gf  = (tap_sel < 100) && zf[c][tap_sel] && hit;
            samp_cur_r[c] = par;
            samp_nxt_r[c] = par ^ gr;
            samp_cur_f[c] = ~par;
            samp_nxt_f[c] = ~par ^ gf;
        end
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog act=%0d exp=%0d", cycles, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
            $finish;
        end
    end

    // Longest zero run with lowest start, centre rounded down.
    task automatic expect_ch(input logic [NT-1:0] m, output int tap, output bit f);
        int best = 0, bst = 0, len = 0, st = 0;
        for (int i = 0; i <= NT; i++) begin
            if (i < NT && !m[i]) begin
                if (len == 0) st = i;
                len++;
            end else begin
                if (len > best) begin best = len; bst = st; end
                len = 0;
            end
        end
        tap = bst + (best - 1) / 2;
        f   = (best < 13);
    endtask

    function automatic logic [NT-1:0] exp_map(input int c, input bit dual, input bit ignored);
        logic [99:0] z;
        z = ignored ? '0 : (zr[c] | (dual ? zf[c] : '0));
        return {1'b0, z};
    endfunction

    task automatic band(input int c, input int lo, input int hi);
        for (int k = lo; k <= hi; k++) if (k >= 0 && k < 100) zr[c][k] = 1'b1;
    endtask

    task automatic clear_zones();
        for (int c = 0; c < NCH; c++) begin zr[c] = '0; zf[c] = '0; end
    endtask

    // One calibration run with all result checks; ignored=1 when zones fall on settle cycles.
    task automatic run_cal(input bit dual, input bit ignored, input bit poke);
        int n = 0, exp_busy, et;
        bit ef;
        obs_len   = dual ? OBS / 2 : OBS;
        exp_busy  = 100 * (1 + obs_len) + 103;
        sweep_err = 0;
        bcnt      = 0;
        @(negedge clk);
        dual_edge = dual;
        start     = 1'b1;
        @(negedge clk);
        start     = 1'b0;
        chk(busy == 1'b1, "R12 busy after start", busy, 1);
        chk(fail == '0, "R11 fail cleared", fail, 0);
        for (int c = 0; c < NCH; c++)
            chk(sel_tap[c*TW +: TW] == 50, "R11 tap reset to centre", sel_tap[c*TW +: TW], 50);
        chk(map_out == '0, "R10 map hidden while busy", (map_out != '0), 0);
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
            if (poke) start = (n == 300);
        end
        start = 1'b0;
        chk(done && !busy, "R12 done with busy low", busy, 0);
        chk(bcnt == exp_busy, "R12 busy length", bcnt, exp_busy);
        chk(sweep_err == 0, "R2 tap order and hold", sweep_err, 0);
        @(negedge clk);
        chk(done == 1'b0, "R12 done one cycle", done, 0);
        for (int c = 0; c < NCH; c++) begin
            expect_ch(exp_map(c, dual, ignored), et, ef);
            chk(sel_tap[c*TW +: TW] == et, "R5 R8 selected tap", sel_tap[c*TW +: TW], et);
            chk(fail[c] == ef, "R6 R8 fail flag", fail[c], ef);
            map_ch = 2'(c);
            #1;
            chk(map_out == exp_map(c, dual, ignored), "R3 R10 map readout", $countones(map_out),
                $countones(exp_map(c, dual, ignored)));
        end
    endtask

    initial begin
        clear_zones();
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy == 0 && done == 0, "R1 idle after reset", busy, 0);
        for (int c = 0; c < NCH; c++)
            chk(sel_tap[c*TW +: TW] == 50 && fail[c] == 0, "R1 reset tap", sel_tap[c*TW +: TW], 50);
        chk(map_out == '0, "R1 map empty", $countones(map_out), 0);
        rst_n = 1'b1;

        // R7: no transitions anywhere
        run_cal(1'b0, 1'b0, 1'b0);

        // R5 tie and even run, R6 narrow eyes, all-transition channel
        clear_zones();
        zr[0][33] = 1'b1; zr[0][67] = 1'b1;
        zr[1][20] = 1'b1;
        for (int k = 0; k < 100; k += 12) zr[2][k] = 1'b1;
        band(3, 0, 99);
        run_cal(1'b0, 1'b0, 1'b0);

        // R6 boundary at 13 and 12 stable taps, R5 tie at mid span
        clear_zones();
        band(0, 0, 40); band(0, 54, 99);
        band(1, 0, 40); band(1, 53, 99);
        band(2, 45, 55);
        band(3, 90, 99);
        run_cal(1'b0, 1'b0, 1'b0);

        // R8 sweep of generated band positions and widths per channel
        for (int j = 0; j < 8; j++) begin
            clear_zones();
            for (int c = 0; c < NCH; c++) begin
                int lo;
                lo = (j * 11 + c * 17) % 90;
                band(c, lo, lo + 2 + j + c);
                band(c, (lo + 37 + 5 * c) % 100, (lo + 41 + 5 * c + j) % 100);
            end
            run_cal(1'b0, 1'b0, 1'b0);
        end

        // R4: falling-edge zones ignored in single-edge mode, counted in double-edge mode
        clear_zones();
        for (int c = 0; c < NCH; c++) begin
            for (int k = 10 + 5 * c; k <= 60; k++) zf[c][k] = 1'b1;
            zr[c][80 + c] = 1'b1;
        end
        run_cal(1'b0, 1'b0, 1'b0);
        run_cal(1'b1, 1'b0, 1'b0);

        // R3: a mismatch on the last observing cycle counts; one in the settle cycle does not
        clear_zones();
        band(0, 5, 40); band(1, 30, 70); band(2, 60, 95); band(3, 1, 20);
        gph = OBS;
        run_cal(1'b0, 1'b0, 1'b0);
        gph = OBS / 2;
        run_cal(1'b1, 1'b0, 1'b0);
        gph = 0;
        run_cal(1'b0, 1'b1, 1'b0);
        gph = -1;

        // R11: extra start during a sweep changes neither length nor results
        run_cal(1'b0, 1'b0, 1'b1);

        // R9: override in range replaces the tap, out of range or disabled does not
        begin
            int et1;
            bit ef1;
            expect_ch(exp_map(1, 1'b0, 1'b0), et1, ef1);
            ovr_en[1] = 1'b1; ovr_tap[1*TW +: TW] = 7'd7;
            #1 chk(sel_tap[1*TW +: TW] == 7, "R9 override applied", sel_tap[1*TW +: TW], 7);
            chk(fail[1] == ef1, "R9 fail kept", fail[1], ef1);
            chk(sel_tap[0*TW +: TW] != 7 || et1 == 7, "R9 R8 other channel untouched", sel_tap[0*TW +: TW], 0);
            ovr_tap[1*TW +: TW] = 7'd101;
            #1 chk(sel_tap[1*TW +: TW] == et1, "R9 out-of-range override ignored", sel_tap[1*TW +: TW], et1);
            ovr_tap[1*TW +: TW] = 7'd100;
            #1 chk(sel_tap[1*TW +: TW] == 100, "R9 override at last tap", sel_tap[1*TW +: TW], 100);
            ovr_en[1] = 1'b0;
            #1 chk(sel_tap[1*TW +: TW] == et1, "R9 disabled override ignored", sel_tap[1*TW +: TW], et1);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
        $finish;
    end
endmodule